// File: doc/BRIEF.md
# Command Ring Queue Controller

This block runs the memory-resident command queue of an interrupt translation unit. Software places 32-byte commands in a ring buffer in memory. It describes that buffer through a base register, which holds the physical base and a size counted in 4 KB pages. It then announces new work by moving a write pointer forward. The block keeps a read pointer of its own. While the two pointers differ, it fetches one command at a time from memory and passes it to a downstream command consumer over a 256-bit valid/ready channel.

The block exposes four 64-bit registers through a simple register port that accepts 64-bit or 32-bit accesses: control, queue base, write pointer and read pointer. The control register carries an enable bit and a quiescent flag. While enabled, the queue base is locked. Rewriting the base while disabled empties the queue by zeroing both pointers. The block neither decodes nor executes commands, and it does not model any bus fabric.

Top module: `cmdq_ctrl`

## Requirements
- R1: The queue holds (base register bits 7:0 + 1) × 4096 bytes. A write-pointer update keeps only bits 19:5 of the merged value, and all other bits read back as zero.
- R2: A write-pointer update whose masked value is greater than or equal to the queue size leaves the write pointer unchanged.
- R3: For each command slot it consumes, the read pointer moves forward by 32. It returns to 0 when it reaches the queue size and always stays below the size.
- R4: When a memory fetch returns with the error flag set, no command is presented for that slot, and the read pointer still moves past it.
- R5: Writes to the base register are ignored while the enable bit is 1. Writes to the read pointer are always ignored.
- R6: A base-register write that is accepted sets both the read pointer and the write pointer to 0.
- R7: The stored base keeps every written bit except 51:48 and 15:12, which are forced to 0. Each fetch goes to address base[47:12]×4096 + read pointer, and the returned 256-bit word is presented unchanged on cmd_data.
- R8: The control register reads bit 0 as the enable value last written and bit 1 as quiescent, which is 1 exactly when the read and write pointers are equal. Every other bit reads 0.
- R9: reg_addr[4:3] selects the register: 0 = control (offset 0x00), 1 = base (0x08), 2 = write pointer (0x10), 3 = read pointer (0x18). When reg_wide is 1, all 64 bits are accessed. Otherwise reg_addr[2] picks the upper (1) or lower (0) half, data travels in bits 31:0, the other half is kept on a write, and read bits 63:32 are 0.
- R10: While cmd_valid is 1 and cmd_ready is 0, cmd_valid and cmd_data stay stable, the read pointer does not move, and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register byte offset |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr and reg_wide |
| mem_req_valid | output | 1 | Command fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Byte address of the command slot |
| mem_rsp_valid | input | 1 | Fetch response strobe |
| mem_rsp_err | input | 1 | Fetch failed |
| mem_rsp_data | input | 256 | Fetched command word |
| cmd_valid | output | 1 | Command presented to the consumer |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_data | output | 256 | Command word |

## Verification
The bench builds the block with its default parameters: a 48-bit physical address, an 8-bit page-count field and 256-bit commands. With these values the smallest queue is one 4 KB page of 128 slots, so a full lap around the ring and the wrap back to zero finish within a few hundred cycles. The same setting lets the largest 256-page queue be programmed, which tests write-pointer acceptance and masking at the top of the 20-bit pointer range without draining a megabyte of commands.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int REG_AW = 5;
  localparam int REG_DW = 64;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_WPTR = 2'd2,
    SEL_RPTR = 2'd3
  } cmdq_reg_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_HOLD = 2'd3
  } cmdq_fetch_e;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_QUIET = 1;

  // Merge a 32- or 64-bit write into the current register value.
  function automatic logic [REG_DW-1:0] cmdq_merge(
    input logic [REG_DW-1:0] cur,
    input logic [REG_DW-1:0] wd,
    input logic              wide,
    input logic              upper
  );
    logic [REG_DW-1:0] m;
    if (wide)       m = wd;
    else if (upper) m = {wd[31:0], cur[31:0]};
    else            m = {cur[63:32], wd[31:0]};
    return m;
  endfunction

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int PA_W      = 48,
  parameter int SZ_W      = 8,
  parameter int PAGE_LSB  = 12,
  parameter int ALIGN_LSB = 16,
  parameter int CMD_LSB   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_valid,
  input  logic                       reg_write,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic                       reg_wide,
  input  logic [REG_DW-1:0]          reg_wdata,
  output logic [REG_DW-1:0]          reg_rdata,
  input  logic [SZ_W+PAGE_LSB-1:0]   rptr,
  output logic [SZ_W+PAGE_LSB-1:0]   wptr,
  output logic [SZ_W+PAGE_LSB:0]     q_size,
  output logic [PA_W-PAGE_LSB-1:0]   base_page,
  output logic                       base_clr
);

  localparam int PTR_W  = SZ_W + PAGE_LSB;
  localparam int SIZE_W = PTR_W + 1;
  localparam logic [REG_DW-1:0] LOW_CLR   = ((64'd1 << (ALIGN_LSB - PAGE_LSB)) - 64'd1) << PAGE_LSB;
  localparam logic [REG_DW-1:0] HIGH_CLR  = 64'hF << PA_W;
  localparam logic [REG_DW-1:0] BASE_KEEP = ~(LOW_CLR | HIGH_CLR);
  localparam logic [PTR_W-1:0]  PTR_KEEP  = {PTR_W{1'b1}} << CMD_LSB;

  logic              enable_q;
  logic [REG_DW-1:0] base_q;
  logic [PTR_W-1:0]  wptr_q;

  cmdq_reg_e         sel;
  logic              upper;
  logic              wr;
  logic              quiet;
  logic [REG_DW-1:0] ctrl_val;
  logic [REG_DW-1:0] cur;
  logic [REG_DW-1:0] merged;
  logic [PTR_W-1:0]  wptr_cand;
  logic              base_wr_ok;
  logic              wptr_wr_ok;
  logic              ctrl_wr;
  logic              enable_d;
  logic [REG_DW-1:0] base_d;
  logic [PTR_W-1:0]  wptr_d;
  logic              wptr_en;

  // decode and next-state
  always_comb begin
    sel   = cmdq_reg_e'(reg_addr[4:3]);
    upper = reg_addr[2];
    wr    = reg_valid & reg_write;
    quiet = (rptr == wptr_q);

    ctrl_val             = '0;
    ctrl_val[CTRL_EN]    = enable_q;
    ctrl_val[CTRL_QUIET] = quiet;

    case (sel)
      SEL_CTRL: cur = ctrl_val;
      SEL_BASE: cur = base_q;
      SEL_WPTR: cur = REG_DW'(wptr_q);
      default:  cur = REG_DW'(rptr);
    endcase

    merged    = cmdq_merge(cur, reg_wdata, reg_wide, upper);
    wptr_cand = merged[PTR_W-1:0] & PTR_KEEP;
    q_size    = (SIZE_W'(base_q[SZ_W-1:0]) + SIZE_W'(1)) << PAGE_LSB;

    base_wr_ok = wr && (sel == SEL_BASE) && !enable_q;
    wptr_wr_ok = wr && (sel == SEL_WPTR) && ({1'b0, wptr_cand} < q_size);
    ctrl_wr    = wr && (sel == SEL_CTRL) && (reg_wide || !upper);

    enable_d = reg_wdata[CTRL_EN];
    base_d   = merged & BASE_KEEP;
    wptr_d   = base_wr_ok ? '0 : wptr_cand;
    wptr_en  = base_wr_ok | wptr_wr_ok;

    if (reg_wide)   reg_rdata = cur;
    else if (upper) reg_rdata = {32'd0, cur[63:32]};
    else            reg_rdata = {32'd0, cur[31:0]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      base_q   <= '0;
      wptr_q   <= '0;
    end else begin
      if (ctrl_wr)    enable_q <= enable_d;
      if (base_wr_ok) base_q   <= base_d;
      if (wptr_en)    wptr_q   <= wptr_d;
    end
  end

  assign wptr      = wptr_q;
  assign base_page = base_q[PA_W-1:PAGE_LSB];
  assign base_clr  = base_wr_ok;

  // R5: base cannot change while enabled
  p_base_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enable_q |=> $stable(base_q));

  // R2: write pointer never points outside the queue
  p_wptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wptr_q} < q_size));

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_pkg::*;
#(
  parameter int PA_W     = 48,
  parameter int SZ_W     = 8,
  parameter int PAGE_LSB = 12,
  parameter int CMD_W    = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [SZ_W+PAGE_LSB-1:0]  wptr,
  input  logic [SZ_W+PAGE_LSB:0]    q_size,
  input  logic [PA_W-PAGE_LSB-1:0]  base_page,
  output logic [SZ_W+PAGE_LSB-1:0]  rptr,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [PA_W-1:0]           mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic                      mem_rsp_err,
  input  logic [CMD_W-1:0]          mem_rsp_data,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic [CMD_W-1:0]          cmd_data
);

  localparam int PTR_W     = SZ_W + PAGE_LSB;
  localparam int SIZE_W    = PTR_W + 1;
  localparam int CMD_BYTES = CMD_W / 8;

  cmdq_fetch_e       state_q, state_d;
  logic              stale_q, stale_d;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [PA_W-1:0]   addr_q, addr_d;
  logic [CMD_W-1:0]  data_q;
  logic              rptr_en, addr_en, cap_en, done;
  logic [SIZE_W-1:0] nxt_full;
  logic [PTR_W-1:0]  rptr_adv;

  always_comb begin
    nxt_full = {1'b0, rptr_q} + SIZE_W'(CMD_BYTES);
    rptr_adv = (nxt_full == q_size) ? '0 : nxt_full[PTR_W-1:0];
    addr_d   = {base_page, {PAGE_LSB{1'b0}}} + PA_W'(rptr_q);

    state_d = state_q;
    stale_d = stale_q;
    addr_en = 1'b0;
    cap_en  = 1'b0;
    done    = 1'b0;

    case (state_q)
      FS_IDLE: begin
        if (!clr && (rptr_q != wptr)) begin
          state_d = FS_REQ;
          addr_en = 1'b1;
        end
      end
      FS_REQ: begin
        if (mem_req_ready) state_d = FS_WAIT;
      end
      FS_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            done    = 1'b1;
            state_d = FS_IDLE;
          end else begin
            cap_en  = 1'b1;
            state_d = FS_HOLD;
          end
        end
      end
      default: begin
        if (cmd_ready) begin
          done    = 1'b1;
          state_d = FS_IDLE;
        end
      end
    endcase

    // a slot fetched before a base rewrite must not move the new pointer
    if (state_d == FS_IDLE) stale_d = 1'b0;
    else if (clr)           stale_d = 1'b1;

    rptr_en = clr | (done & ~stale_q);
    rptr_d  = clr ? '0 : rptr_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      stale_q <= 1'b0;
      rptr_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      stale_q <= stale_d;
      if (rptr_en) rptr_q <= rptr_d;
      if (addr_en) addr_q <= addr_d;
      if (cap_en)  data_q <= mem_rsp_data;
    end
  end

  assign rptr          = rptr_q;
  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_req_addr  = addr_q;
  assign cmd_valid     = (state_q == FS_HOLD);
  assign cmd_data      = data_q;

  // R10: held command stays put
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R10: pointer frozen while the consumer stalls
  p_rptr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !clr) |=> $stable(rptr_q));

  // R7: request address stable until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: pointer only stays, steps by one slot, or wraps to zero
  p_rptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (rptr_q == $past(rptr_q) || rptr_q == $past(rptr_q) + PTR_W'(CMD_BYTES)
              || rptr_q == '0));

  // R3: pointer stays inside the queue
  p_rptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rptr_q} < q_size));

endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int PA_W      = 48,
  parameter int SZ_W      = 8,
  parameter int PAGE_LSB  = 12,
  parameter int ALIGN_LSB = 16,
  parameter int CMD_W     = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wide,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [PA_W-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic                 mem_rsp_err,
  input  logic [CMD_W-1:0]     mem_rsp_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [CMD_W-1:0]     cmd_data
);

  localparam int CMD_LSB = $clog2(CMD_W / 8);
  localparam int PTR_W   = SZ_W + PAGE_LSB;
  localparam int SIZE_W  = PTR_W + 1;
  localparam int PG_W    = PA_W - PAGE_LSB;

  logic [PTR_W-1:0]  rptr;
  logic [PTR_W-1:0]  wptr;
  logic [SIZE_W-1:0] q_size;
  logic [PG_W-1:0]   base_page;
  logic              base_clr;

  cmdq_regs #(
    .PA_W(PA_W), .SZ_W(SZ_W), .PAGE_LSB(PAGE_LSB),
    .ALIGN_LSB(ALIGN_LSB), .CMD_LSB(CMD_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rptr(rptr), .wptr(wptr), .q_size(q_size),
    .base_page(base_page), .base_clr(base_clr)
  );

  cmdq_fetch #(
    .PA_W(PA_W), .SZ_W(SZ_W), .PAGE_LSB(PAGE_LSB), .CMD_W(CMD_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .clr(base_clr), .wptr(wptr), .q_size(q_size), .base_page(base_page),
    .rptr(rptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  // R6: accepted base write empties the queue
  p_clear_ptrs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    base_clr |=> (wptr == '0 && rptr == '0));

endmodule

// File: tb/cmdq_ctrl_bench.sv
module cmdq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PA_W  = 48;
  localparam int CMD_W = 256;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_BASE = 5'h08;
  localparam logic [4:0] A_WPTR = 5'h10;
  localparam logic [4:0] A_RPTR = 5'h18;

  // {size field, write-pointer data, expected pointer}
  localparam logic [91:0] VECS [8] = '{
    {8'h00, 64'h0000_0000_0000_0040, 20'h00040},
    {8'h00, 64'h0000_0000_0000_1000, 20'h00000},
    {8'h00, 64'h0000_0000_0000_0FE0, 20'h00FE0},
    {8'h00, 64'h0000_0000_0000_0047, 20'h00040},
    {8'h01, 64'h0000_0000_0000_1FE0, 20'h01FE0},
    {8'h01, 64'h0000_0000_0000_2000, 20'h00000},
    {8'h00, 64'hFFFF_FFFF_FFF0_0060, 20'h00060},
    {8'hFF, 64'h0000_0000_0000_0400, 20'h00400}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              reg_valid, reg_write, reg_wide;
  logic [4:0]        reg_addr;
  logic [63:0]       reg_wdata, reg_rdata;
  logic              mem_req_valid, mem_req_ready;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid, mem_rsp_err;
  logic [CMD_W-1:0]  mem_rsp_data;
  logic              cmd_valid, cmd_ready;
  logic [CMD_W-1:0]  cmd_data;

  cmdq_ctrl u_cmdq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int ncmd     = 0;
  bit finished = 1'b0;
  logic [47:0] tb_base, bad_addr, exp_addr;
  logic [20:0] tb_size;
  logic        bad_en;

  function automatic logic [CMD_W-1:0] pattern(input logic [47:0] a);
    return {8{a[31:0] ^ 32'h5A00_00C3}};
  endfunction

  function automatic logic [47:0] step(input logic [47:0] a);
    logic [47:0] off;
    off = a - tb_base + 48'd32;
    if (off == 48'(tb_size)) off = '0;
    return tb_base + off;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle response
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= pattern(mem_req_addr);
    mem_rsp_err   <= bad_en && (mem_req_addr == bad_addr);
  end

  // consumer monitor: R7 address/data, R4 skip of failed slot
  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      logic [47:0] a;
      a = exp_addr;
      if (bad_en && a == bad_addr) a = step(a);
      check(cmd_data == pattern(a), "R7 cmd data", cmd_data, pattern(a));
      exp_addr = step(a);
      ncmd++;
    end
  end

  task automatic reg_wr(input logic [4:0] a, input logic wide, input logic [63:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wide = wide; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a; reg_wide = wide;
    #1;
    d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [63:0] c;
    bit got;
    got = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(A_CTRL, 1'b1, c);
      if (c[1]) begin
        got = 1'b1;
        break;
      end
    end
    check(got, "R8 quiescent reached", 256'(got), 256'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    rst_n = 1'b0;
    reg_valid = 1'b0; reg_write = 1'b0; reg_wide = 1'b1; reg_addr = '0; reg_wdata = '0;
    mem_req_ready = 1'b1; cmd_ready = 1'b1; bad_en = 1'b0; bad_addr = '0;
    tb_base = '0; tb_size = 21'h1000; exp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(A_CTRL, 1'b1, rd); check(rd == 64'h2, "R8 reset ctrl", 256'(rd), 256'h2);
    reg_rd(A_BASE, 1'b1, rd); check(rd == 64'h0, "R7 reset base", 256'(rd), 256'h0);
    reg_rd(A_WPTR, 1'b1, rd); check(rd == 64'h0, "R1 reset wptr", 256'(rd), 256'h0);
    reg_rd(A_RPTR, 1'b1, rd); check(rd == 64'h0, "R3 reset rptr", 256'(rd), 256'h0);
    check(!cmd_valid && !mem_req_valid, "R10 reset idle", 256'({cmd_valid, mem_req_valid}), 256'h0);

    // vector table: size, masking, range, drain
    for (int i = 0; i < 8; i++) begin
      logic [91:0] v;
      v = VECS[i];
      tb_base  = 48'h1234_0000;
      tb_size  = (21'(v[91:84]) + 21'd1) << 12;
      exp_addr = tb_base;
      ncmd     = 0;
      reg_wr(A_BASE, 1'b1, 64'h1234_5000 | 64'(v[91:84]));
      reg_rd(A_BASE, 1'b1, rd);
      check(rd == (64'h1234_0000 | 64'(v[91:84])), "R7 base sanitised", 256'(rd),
            256'(64'h1234_0000 | 64'(v[91:84])));
      reg_wr(A_WPTR, 1'b1, v[83:20]);
      reg_rd(A_WPTR, 1'b1, rd);
      check(rd == 64'(v[19:0]), "R1 R2 wptr update", 256'(rd), 256'(v[19:0]));
      wait_idle();
      reg_rd(A_RPTR, 1'b1, rd);
      check(rd == 64'(v[19:0]), "R3 rptr drained", 256'(rd), 256'(v[19:0]));
      check(ncmd == int'(v[19:5]), "R3 command count", 256'(ncmd), 256'(v[19:5]));
    end

    // R7 sanitising of all-ones base
    reg_wr(A_BASE, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_rd(A_BASE, 1'b1, rd);
    check(rd == 64'hFFF0_FFFF_FFFF_0FFF, "R7 clear 51:48 15:12", 256'(rd), 256'hFFF0_FFFF_FFFF_0FFF);

    // R9 narrow accesses
    reg_wr(A_BASE, 1'b0, 64'h0001_0000);
    reg_rd(A_BASE | 5'h4, 1'b0, rd);
    check(rd == 64'hFFF0_FFFF, "R9 narrow upper read", 256'(rd), 256'hFFF0_FFFF);
    reg_rd(A_BASE, 1'b0, rd);
    check(rd == 64'h0001_0000, "R9 narrow lower read", 256'(rd), 256'h0001_0000);
    reg_wr(A_BASE | 5'h4, 1'b0, 64'h0);
    reg_rd(A_BASE, 1'b1, rd);
    check(rd == 64'h0001_0000, "R9 narrow upper write", 256'(rd), 256'h0001_0000);

    // R7 fetch address from base
    tb_base = 48'h1_0000; tb_size = 21'h1000; exp_addr = tb_base; ncmd = 0;
    reg_wr(A_WPTR, 1'b1, 64'h20);
    wait_idle();
    check(ncmd == 1, "R7 single command", 256'(ncmd), 256'd1);

    // R3 wrap at size
    reg_wr(A_WPTR, 1'b1, 64'hFE0);
    wait_idle();
    check(ncmd == 127, "R3 fill to last slot", 256'(ncmd), 256'd127);
    reg_wr(A_WPTR, 1'b1, 64'h40);
    wait_idle();
    check(ncmd == 130, "R3 wrap count", 256'(ncmd), 256'd130);
    reg_rd(A_RPTR, 1'b1, rd);
    check(rd == 64'h40, "R3 rptr after wrap", 256'(rd), 256'h40);

    // R4 failed fetch skipped
    bad_addr = 48'h1_0060; bad_en = 1'b1;
    reg_wr(A_WPTR, 1'b1, 64'hA0);
    wait_idle();
    check(ncmd == 132, "R4 failed slot not presented", 256'(ncmd), 256'd132);
    reg_rd(A_RPTR, 1'b0, rd);
    check(rd == 64'hA0, "R4 rptr past failed slot", 256'(rd), 256'hA0);
    reg_rd(A_RPTR | 5'h4, 1'b0, rd);
    check(rd == 64'h0, "R9 rptr upper half", 256'(rd), 256'h0);

    // R10 backpressure
    bad_en = 1'b0;
    cmd_ready = 1'b0;
    reg_wr(A_WPTR, 1'b1, 64'hE0);
    repeat (10) @(negedge clk);
    check(cmd_valid == 1'b1, "R10 cmd held valid", 256'(cmd_valid), 256'd1);
    check(cmd_data == pattern(48'h1_00A0), "R10 held data", cmd_data, pattern(48'h1_00A0));
    check(mem_req_valid == 1'b0, "R10 no fetch while held", 256'(mem_req_valid), 256'd0);
    reg_rd(A_RPTR, 1'b1, rd);
    check(rd == 64'hA0, "R10 rptr frozen", 256'(rd), 256'hA0);
    reg_rd(A_CTRL, 1'b1, rd);
    check(rd == 64'h0, "R8 busy not quiescent", 256'(rd), 256'h0);
    cmd_ready = 1'b1;
    wait_idle();
    reg_rd(A_RPTR, 1'b1, rd);
    check(rd == 64'hE0, "R10 drained after release", 256'(rd), 256'hE0);
    check(ncmd == 134, "R10 count after release", 256'(ncmd), 256'd134);

    // R5 enable lock, read pointer writes ignored
    reg_wr(A_CTRL, 1'b1, 64'h1);
    reg_rd(A_CTRL, 1'b1, rd);
    check(rd == 64'h3, "R8 enable and quiescent", 256'(rd), 256'h3);
    reg_wr(A_BASE, 1'b1, 64'h0555_0000);
    reg_rd(A_BASE, 1'b1, rd);
    check(rd == 64'h1_0000, "R5 base locked", 256'(rd), 256'h1_0000);
    reg_rd(A_WPTR, 1'b1, rd);
    check(rd == 64'hE0, "R5 wptr kept on locked write", 256'(rd), 256'hE0);
    reg_wr(A_RPTR, 1'b1, 64'h40);
    reg_rd(A_RPTR, 1'b1, rd);
    check(rd == 64'hE0, "R5 rptr write ignored", 256'(rd), 256'hE0);
    reg_wr(A_CTRL, 1'b1, 64'h0);
    reg_rd(A_CTRL, 1'b1, rd);
    check(rd == 64'h2, "R8 enable cleared", 256'(rd), 256'h2);

    // R6 accepted base write clears pointers
    reg_wr(A_BASE, 1'b1, 64'h2_0000);
    reg_rd(A_BASE, 1'b1, rd);
    check(rd == 64'h2_0000, "R6 base accepted", 256'(rd), 256'h2_0000);
    reg_rd(A_WPTR, 1'b1, rd);
    check(rd == 64'h0, "R6 wptr cleared", 256'(rd), 256'h0);
    reg_rd(A_RPTR, 1'b1, rd);
    check(rd == 64'h0, "R6 rptr cleared", 256'(rd), 256'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule